// File: doc/BRIEF.md
# MDIO Management Shift Engine

This block runs one PHY management transaction at a time over a two-wire management bus. Software writes a complete 32-bit management frame (start code, opcode, PHY and register addresses, turnaround and data) into a single register. The write starts the transaction at once. The block does not format the frame, so software must write a fully valid frame. Clause 22 and clause 45 frames are both accepted. Their differing start and opcode bits are sent exactly as written. Preamble bits are not produced here.

The frame register is a 32-bit circular shift register that serves as both command and result. The management clock is made from the system clock by a programmable divider. On every management clock period the register's top bit goes out on the data line and the bottom bit is refilled from the data line. After 32 periods every bit is back in its original place. On a read, the data field then holds what the PHY returned. Software may read the register at any moment and sees its live contents. An idle flag and a one-cycle interrupt pulse mark completion.

The control is a three-state machine:
- **ST_IDLE**: no transaction; the clock is low and the line is released.
- **ST_LOW**: the clock is low and the output bit is steady.
- **ST_HIGH**: the clock is high and the input bit has been sampled.

The transitions are:
- **ST_IDLE → ST_LOW** (*start*): on a write while idle.
- **ST_LOW → ST_HIGH** (*rise*): on a divider tick; the input is sampled.
- **ST_HIGH → ST_LOW** (*fall*): on a divider tick with bits still to go; the register shifts.
- **ST_HIGH → ST_IDLE** (*finish*): on the tick that ends the 32nd period; the register shifts for the last time.

Top module: `mdio_shift_engine`

## Requirements
- R1: After reset, `mdc`, `mdio_oe` and `irq` are 0, `mgmt_idle` is 1, and `rd_data` is all zeros.
- R2: In each management clock period, `mdc` is low for `mdc_half`+1 system clock cycles and then high for `mdc_half`+1 cycles. The low phase comes first. Exactly 32 high pulses make up one transaction, and `mdc` stays low while idle. `mdc_half` is captured when the transaction starts.
- R3: `mdio_o` always equals bit 31 of the frame register. It changes only when the write is accepted and on falling edges of `mdc`.
- R4: On each falling edge of `mdc`, the register shifts left by one bit. Bit 0 takes the `mdio_i` value sampled on the preceding rising edge. After 32 periods the register holds the 32 sampled bits, with the first-sampled bit in bit 31.
- R5: `rd_data` shows the live register contents in every cycle, including during a transaction.
- R6: In the cycle after the last falling edge, `mgmt_idle` returns to 1 and `irq` is high for exactly that one cycle.
- R7: A `wr_en` while idle is accepted at that clock edge. The register loads `wr_data`, `mgmt_idle` clears, and shifting begins. A `wr_en` during a transaction has no effect on any output.
- R8: `mdio_oe` is 0 while idle and 1 during a transaction. The exception is a read frame, where the opcode in bits 29:28 equals 2'b10. For a read frame, `mdio_oe` drops to 0 once 14 falling edges have passed and stays 0 until the end, covering the turnaround and data bits 17:0.
- R9: Frame bits go out unmodified whatever their start code. A clause 45 frame (bits 31:30 = 2'b00) and a clause 22 frame (bits 31:30 = 2'b01) both go out MSB first, exactly as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Frame written to the register |
| mdc_half | input | DIV_W | Half-period of the management clock, minus one, in system clock cycles |
| rd_data | output | 32 | Live register contents |
| mgmt_idle | output | 1 | High when no transaction is running |
| irq | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench builds the block with DIV_W = 4 and FRAME_W = 32. It runs transactions with `mdc_half` set to 0, 1, 2 and 5. The value 0 gives the fastest clock, where a phase lasts a single system cycle and sampling and shifting fall in adjacent cycles. The larger values expose miscounted phase lengths. With a narrow divider and modest values, each 32-bit transaction stays within a few hundred cycles. This leaves room for write frames with loopback, read frames with a PHY pattern, a clause 45 frame, a write ignored mid-transaction and back-to-back starts.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } mdio_state_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == half_div);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= half_div));
endmodule

// File: rtl/mdio_rot_reg.sv
module mdio_rot_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         sample,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] q
);
    logic samp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            samp_q <= 1'b0;
        end else begin
            if (sample) begin
                samp_q <= din;
            end
            if (load) begin
                q <= load_val;
            end else if (shift) begin
                q <= {q[W-2:0], samp_q};
            end
        end
    end
endmodule

// File: rtl/mdio_shift_engine.sv
module mdio_shift_engine
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FRAME_W-1:0] wr_data,
    input  logic [DIV_W-1:0]   mdc_half,
    output logic [FRAME_W-1:0] rd_data,
    output logic               mgmt_idle,
    output logic               irq,
    output logic               mdc,
    output logic               mdio_o,
    output logic               mdio_oe,
    input  logic               mdio_i
);
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam int REL_POS = FRAME_W - 18;
    localparam int OP_HI   = FRAME_W - 3;
    localparam int OP_LO   = FRAME_W - 4;

    mdio_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_q;
    logic             rd_op_q;
    logic             idle_q;
    logic             irq_q;
    logic             tick;
    logic             load;
    logic             sample;
    logic             shift;
    logic             last;
    logic [FRAME_W-1:0] shreg;

    assign load   = wr_en && (state_q == ST_IDLE);
    assign sample = (state_q == ST_LOW) && tick;
    assign shift  = (state_q == ST_HIGH) && tick;
    assign last   = shift && (cnt_q == CNT_W'(FRAME_W - 1));

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q != ST_IDLE),
        .half_div (div_q),
        .tick     (tick)
    );

    mdio_rot_reg #(.W(FRAME_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (wr_data),
        .sample   (sample),
        .shift    (shift),
        .din      (mdio_i),
        .q        (shreg)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load)  state_d = ST_LOW;
            ST_LOW:  if (tick)  state_d = ST_HIGH;
            ST_HIGH: if (last)  state_d = ST_IDLE;
                     else if (tick) state_d = ST_LOW;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            div_q   <= '0;
            rd_op_q <= 1'b0;
            idle_q  <= 1'b1;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= last;
            if (load) begin
                cnt_q   <= '0;
                div_q   <= mdc_half;
                rd_op_q <= (wr_data[OP_HI:OP_LO] == 2'b10);
                idle_q  <= 1'b0;
            end else if (shift) begin
                cnt_q <= cnt_q + 1'b1;
                if (last) begin
                    idle_q <= 1'b1;
                end
            end
        end
    end

    assign rd_data   = shreg;
    assign mgmt_idle = idle_q;
    assign irq       = irq_q;
    assign mdc       = (state_q == ST_HIGH);
    assign mdio_o    = shreg[FRAME_W-1];
    assign mdio_oe   = (state_q != ST_IDLE) &&
                       !(rd_op_q && (cnt_q >= CNT_W'(REL_POS)));

    // R2
    mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_idle |-> !mdc);

    // R3
    mdio_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mgmt_idle && !$fell(mdc) && !$past(mgmt_idle)) |-> $stable(mdio_o));

    // R6
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> mgmt_idle);

    // R6
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R8
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_idle |-> !mdio_oe);
endmodule

// File: tb/mdio_shift_engine_test.sv
`timescale 1ns/1ps
module mdio_shift_engine_test;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [DW-1:0] mdc_half = '0;
    logic [31:0]   rd_data;
    logic          mgmt_idle, irq, mdc, mdio_o, mdio_oe, mdio_i;
    logic [31:0]   phy_pat = '0;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // behavioural reference state
    bit          m_busy, m_high, m_done, m_irq, m_rd, m_samp;
    int          m_wait, m_div, m_bits;
    logic [31:0] m_reg;

    int rises, irqs;
    logic prev_mdc;

    always #2.5 clk = ~clk;

    mdio_shift_engine #(.DIV_W(DW), .FRAME_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .mdc_half(mdc_half), .rd_data(rd_data), .mgmt_idle(mgmt_idle),
        .irq(irq), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    function automatic bit exp_oe();
        return m_busy && !(m_rd && m_bits >= 14);
    endfunction

    assign mdio_i = mdio_oe ? mdio_o : phy_pat[31 - (m_bits % 32)];

    always @(posedge clk) begin
        m_irq = 1'b0;
        if (!rst_n) begin
            m_busy = 0; m_high = 0; m_done = 1; m_rd = 0; m_samp = 0;
            m_wait = 0; m_div = 0; m_bits = 0; m_reg = '0;
        end else if (!m_busy) begin
            if (wr_en) begin
                m_busy = 1; m_high = 0; m_wait = 0; m_bits = 0;
                m_reg = wr_data; m_done = 0; m_div = int'(mdc_half);
                m_rd = (wr_data[29] == 1'b1) && (wr_data[28] == 1'b0);
            end
        end else if (m_wait == m_div) begin
            m_wait = 0;
            if (!m_high) begin
                m_high = 1;
                m_samp = exp_oe() ? m_reg[31] : phy_pat[31 - m_bits];
            end else begin
                m_high = 0;
                m_reg = (m_reg << 1) | {31'd0, m_samp};
                m_bits++;
                if (m_bits == 32) begin
                    m_bits = 0; m_busy = 0; m_done = 1; m_irq = 1;
                end
            end
        end else begin
            m_wait++;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    task automatic compare();
        chk({31'd0, mdc}, {31'd0, m_busy && m_high}, "R2 mdc");
        chk({31'd0, mdio_o}, {31'd0, m_reg[31]}, "R3 mdio_o");
        chk(rd_data, m_reg, "R5 rd_data");
        chk({31'd0, mgmt_idle}, {31'd0, m_done}, "R7 mgmt_idle");
        chk({31'd0, irq}, {31'd0, m_irq}, "R6 irq");
        chk({31'd0, mdio_oe}, {31'd0, exp_oe()}, "R8 mdio_oe");
        if (mdc && !prev_mdc) rises++;
        if (irq) irqs++;
        prev_mdc = mdc;
    endtask

    task automatic step();
        @(negedge clk);
        compare();
    endtask

    task automatic run_op(input logic [31:0] frame, input int d,
                          input logic [31:0] phy, input int junk_at,
                          input logic [31:0] expect_end);
        rises = 0; irqs = 0;
        wr_en = 1'b1; wr_data = frame; mdc_half = DW'(d); phy_pat = phy;
        step();
        wr_en = 1'b0;
        for (int i = 0; i < 5000 && m_busy; i++) begin
            step();
            if (i == junk_at) begin
                wr_en = 1'b1; wr_data = ~frame; mdc_half = DW'(0);
            end else begin
                wr_en = 1'b0;
            end
        end
        wr_en = 1'b0;
        step();
        chk(32'(rises), 32'd32, "R2 mdc pulses per op");
        chk(32'(irqs), 32'd1, "R6 irq pulses per op");
        chk(rd_data, expect_end, "R4 final register");
    endtask

    initial begin
        prev_mdc = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        chk({31'd0, mgmt_idle}, 32'd1, "R1 idle after reset");
        chk({31'd0, mdc}, 32'd0, "R1 mdc after reset");
        chk({31'd0, mdio_oe}, 32'd0, "R1 oe after reset");
        chk({31'd0, irq}, 32'd0, "R1 irq after reset");
        chk(rd_data, 32'd0, "R1 rd_data after reset");
        // R9 clause 22 write, loopback keeps frame (R4)
        run_op(32'h5A3C_9E21, 0, 32'h0, -1, 32'h5A3C_9E21);
        // read frame with ignored write mid-op (R7, R8)
        run_op(32'h6B8A_0000, 2, 32'h1234_ABCD, 10,
               {32'h6B8A_0000 & 32'hFFFC_0000} | (32'h1234_ABCD & 32'h0003_FFFF));
        // R9 clause 45 frame, opcode 11 keeps line driven
        run_op(32'h3C55_A5F0, 1, 32'hFFFF_FFFF, 40, 32'h3C55_A5F0);
        // read again with slow clock, then back-to-back start (R7)
        run_op(32'h6000_0000, 5, 32'hDEAD_8001,
               -1, 32'h6000_0000 | (32'hDEAD_8001 & 32'h0003_FFFF));
        run_op(32'h5000_FFFF, 0, 32'h0, 3, 32'h5000_FFFF);
        repeat (4) step();
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule